// File: doc/BRIEF.md
# Block-Crossing Memory Access Splitter

This unit sits between a load/store pipeline and the request port of a data cache. It accepts one load or store at a time, with a byte address, a byte count, store data, a lock flag and a swap flag. It also takes two translation-fault inputs, one for each possible fragment. If the bytes touched fall in two cache blocks, the unit breaks the access into two fragment requests. Otherwise it forwards the access as one request.

Both fragments are checked for faults before anything leaves the unit. A fault, or a locked or swap access that would need splitting, ends the access at once with a status and no cache traffic. Fragments go out in ascending order. A refused fragment stays on the port unchanged until it is taken. The second fragment follows directly after the first is accepted.

Responses carry a fragment index and may return in either order. A counter of outstanding fragments decides when the single merged completion is raised. For loads, each fragment's low-aligned data is placed into the merged word at that fragment's byte offset.

Top module: `line_split_lsu`

## Requirements
- R1: After reset `req_ready` is 1, and `mreq_valid` and `done_valid` are 0. `req_ready` is 1 only while no access is in progress, and an access is taken on a cycle where `req_valid` and `req_ready` are both 1.
- R2: Let `b` be (`addr`+`size`−1) rounded down to a multiple of `BLOCK_BYTES`. The access splits when `b` > `addr`. In that case fragment 0 has address `addr` and size `b`−`addr`, and fragment 1 has address `b` and size `size`−(`b`−`addr`). `mreq_frag` carries the fragment index.
- R3: A non-splitting access issues exactly one request, fragment 0, with address `addr` and size `size`. `mreq_cmd` encodes 0 = read, 1 = locked read, 2 = write, 3 = conditional (locked) write.
- R4: If `xlat_fault0` is set, or the access splits and `xlat_fault1` is set, no request is issued. `done_valid` pulses in the cycle after acceptance, with `done_fault`=1 and `done_err`=0. `xlat_fault1` has no effect on an access that does not split.
- R5: A splitting access with `req_lock` or `req_swap` set (and no fault) issues no request. It completes in the cycle after acceptance with `done_err`=1 and `done_fault`=0. A non-splitting swap is issued as a plain write (command 2).
- R6: While `mreq_valid` is 1 and `mreq_ready` is 0, the request fields hold steady. When fragment 0 of a split access is accepted, fragment 1 appears on the port in the very next cycle.
- R7: `done_valid` pulses for one cycle, in the cycle after the last outstanding fragment response arrives (one response when not split, two when split), with both status bits 0. It stays low while any response is still owed.
- R8: For a load, `done_rdata` byte `i` (i < `size`) equals byte `i` of fragment 0's response when i < first size. Otherwise it equals byte (`i`−first size) of fragment 1's response. Bytes at or above `size` are 0, and the response order does not matter.
- R9: For a store, fragment 0 carries the low first-size bytes of `req_wdata` and fragment 1 carries the bytes starting at byte offset first size. Each is placed at byte 0 of `mreq_wdata`, and the bytes above the fragment size are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Unit idle, access can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_lock | input | 1 | Locked (reserve / conditional) access |
| req_swap | input | 1 | Swap access |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SIZE_W | Byte count, 1..DATA_BYTES |
| req_wdata | input | 8*DATA_BYTES | Store data, byte 0 at the address |
| xlat_fault0 | input | 1 | Translation fault on fragment 0 |
| xlat_fault1 | input | 1 | Translation fault on fragment 1 |
| mreq_valid | output | 1 | Cache request valid |
| mreq_ready | input | 1 | Cache accepts the request |
| mreq_cmd | output | 2 | Command encoding per R3 |
| mreq_frag | output | 1 | Fragment index |
| mreq_addr | output | ADDR_W | Fragment byte address |
| mreq_size | output | SIZE_W | Fragment byte count |
| mreq_wdata | output | 8*DATA_BYTES | Fragment store data, low-aligned |
| mresp_valid | input | 1 | Cache response valid |
| mresp_frag | input | 1 | Fragment index of the response |
| mresp_rdata | input | 8*DATA_BYTES | Fragment load data, low-aligned |
| done_valid | output | 1 | Access complete pulse |
| done_fault | output | 1 | Access aborted by translation fault |
| done_err | output | 1 | Access aborted as an unsplittable locked/swap access |
| done_rdata | output | 8*DATA_BYTES | Merged load data |

## Verification
The bench builds the unit with 8-byte blocks, 4-byte maximum accesses and an 8-bit address. With these values, a sweep of every start offset across two full blocks covers every split point for sizes 1, 2 and 4: one-byte first fragments, one-byte second fragments and aligned accesses all occur. Each access is also varied in stall length on the first fragment and in response order. Further directed cases exercise fault placement and locked and swap accesses on both sides of the boundary.

// File: rtl/msplit_pkg.sv
package msplit_pkg;

   typedef enum logic [1:0] {
      MCMD_READ       = 2'd0,
      MCMD_READ_LOCK  = 2'd1,
      MCMD_WRITE      = 2'd2,
      MCMD_WRITE_COND = 2'd3
   } mcmd_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2
   } mstate_e;

endpackage

// File: rtl/msplit_calc.sv
module msplit_calc #(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 64,
   parameter int SIZE_W      = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic              split,
   output logic [SIZE_W-1:0] first_size,
   output logic [SIZE_W-1:0] second_size,
   output logic [ADDR_W-1:0] second_addr,
   output logic              span_ok
);
   localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLOCK_BYTES - 1);

   logic [ADDR_W-1:0] last_byte;
   logic [ADDR_W-1:0] last_blk;
   logic [ADDR_W-1:0] gap;
   logic [ADDR_W-1:0] tail_end;

   always_comb begin
      last_byte   = addr + ADDR_W'(size) - ADDR_W'(1);
      last_blk    = last_byte & BLK_MASK;
      split       = last_blk > addr;
      gap         = last_blk - addr;
      first_size  = split ? gap[SIZE_W-1:0] : size;
      second_size = size - first_size;
      second_addr = last_blk;
      tail_end    = last_blk + ADDR_W'(second_size) - ADDR_W'(1);
      span_ok     = !split || ((tail_end & BLK_MASK) == last_blk);
   end
endmodule

// File: rtl/msplit_pack.sv
module msplit_pack #(
   parameter int DATA_BYTES = 8,
   parameter int SIZE_W     = 4
) (
   input  logic [8*DATA_BYTES-1:0] wdata,
   input  logic                    frag,
   input  logic [SIZE_W-1:0]       first_size,
   input  logic [SIZE_W-1:0]       frag_size,
   output logic [8*DATA_BYTES-1:0] frag_wdata
);
   localparam int DW = 8 * DATA_BYTES;

   logic [SIZE_W-1:0] skip;
   logic [DW-1:0]     shifted;

   assign skip    = frag ? first_size : '0;
   assign shifted = wdata >> {skip, 3'b000};

   for (genvar lane = 0; lane < DATA_BYTES; lane++) begin : g_lane
      assign frag_wdata[8*lane +: 8] =
         (SIZE_W'(lane) < frag_size) ? shifted[8*lane +: 8] : 8'h00;
   end
endmodule

// File: rtl/msplit_merge.sv
module msplit_merge #(
   parameter int DATA_BYTES = 8,
   parameter int SIZE_W     = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    load_en,
   input  logic                    frag,
   input  logic [SIZE_W-1:0]       first_size,
   input  logic [SIZE_W-1:0]       second_size,
   input  logic [8*DATA_BYTES-1:0] rdata,
   output logic [8*DATA_BYTES-1:0] merged
);
   localparam int DW = 8 * DATA_BYTES;

   logic [SIZE_W-1:0] base;
   logic [SIZE_W-1:0] span;
   logic [SIZE_W-1:0] limit;
   logic [DW-1:0]     placed;

   assign base   = frag ? first_size : '0;
   assign span   = frag ? second_size : first_size;
   assign limit  = base + span;
   assign placed = rdata << {base, 3'b000};

   for (genvar lane = 0; lane < DATA_BYTES; lane++) begin : g_lane
      logic hit;
      assign hit = (SIZE_W'(lane) >= base) && (SIZE_W'(lane) < limit);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                merged[8*lane +: 8] <= 8'h00;
         else if (clear)            merged[8*lane +: 8] <= 8'h00;
         else if (load_en && hit)   merged[8*lane +: 8] <= placed[8*lane +: 8];
      end
   end

   assert_lane_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> (limit <= SIZE_W'(DATA_BYTES)));
endmodule

// File: rtl/line_split_lsu.sv
module line_split_lsu
   import msplit_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 64,
   parameter int DATA_BYTES  = 8,
   parameter int SIZE_W      = $clog2(DATA_BYTES) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic                    req_lock,
   input  logic                    req_swap,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [SIZE_W-1:0]       req_size,
   input  logic [8*DATA_BYTES-1:0] req_wdata,
   input  logic                    xlat_fault0,
   input  logic                    xlat_fault1,
   output logic                    mreq_valid,
   input  logic                    mreq_ready,
   output logic [1:0]              mreq_cmd,
   output logic                    mreq_frag,
   output logic [ADDR_W-1:0]       mreq_addr,
   output logic [SIZE_W-1:0]       mreq_size,
   output logic [8*DATA_BYTES-1:0] mreq_wdata,
   input  logic                    mresp_valid,
   input  logic                    mresp_frag,
   input  logic [8*DATA_BYTES-1:0] mresp_rdata,
   output logic                    done_valid,
   output logic                    done_fault,
   output logic                    done_err,
   output logic [8*DATA_BYTES-1:0] done_rdata
);
   localparam int DW    = 8 * DATA_BYTES;
   localparam int OFF_W = $clog2(BLOCK_BYTES);

   if ((BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two");
   end
   if ((DATA_BYTES & (DATA_BYTES - 1)) != 0) begin : g_bad_data
      $error("DATA_BYTES must be a power of two");
   end
   if (BLOCK_BYTES < DATA_BYTES) begin : g_bad_ratio
      $error("an access must fit in two blocks: BLOCK_BYTES >= DATA_BYTES");
   end
   if (ADDR_W <= OFF_W || SIZE_W > ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the block and size fields");
   end

   // split arithmetic on the incoming access
   logic              c_split, c_span_ok;
   logic [SIZE_W-1:0] c_first, c_second;
   logic [ADDR_W-1:0] c_second_addr;

   msplit_calc #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .SIZE_W(SIZE_W)) u_calc (
      .addr        (req_addr),
      .size        (req_size),
      .split       (c_split),
      .first_size  (c_first),
      .second_size (c_second),
      .second_addr (c_second_addr),
      .span_ok     (c_span_ok)
   );

   // held access state
   mstate_e           state;
   logic              r_write, r_lock, r_split, cur_frag;
   logic [1:0]        pend;
   logic [ADDR_W-1:0] r_addr, r_second_addr;
   logic [SIZE_W-1:0] r_first, r_second;
   logic [DW-1:0]     r_wdata;

   logic accept, abort_fault, abort_err, resp_fire;

   assign req_ready   = (state == ST_IDLE);
   assign accept      = req_valid && req_ready;
   assign abort_fault = xlat_fault0 || (c_split && xlat_fault1);
   assign abort_err   = !abort_fault && c_split && (req_lock || req_swap);
   assign resp_fire   = mresp_valid && (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         cur_frag      <= 1'b0;
         pend          <= 2'd0;
         r_write       <= 1'b0;
         r_lock        <= 1'b0;
         r_split       <= 1'b0;
         r_addr        <= '0;
         r_second_addr <= '0;
         r_first       <= '0;
         r_second      <= '0;
         r_wdata       <= '0;
         done_valid    <= 1'b0;
         done_fault    <= 1'b0;
         done_err      <= 1'b0;
      end else begin
         done_valid <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               r_write       <= req_write;
               r_lock        <= req_lock;
               r_split       <= c_split;
               r_addr        <= req_addr;
               r_second_addr <= c_second_addr;
               r_first       <= c_first;
               r_second      <= c_second;
               r_wdata       <= req_wdata;
               done_fault    <= abort_fault;
               done_err      <= abort_err;
               if (abort_fault || abort_err) begin
                  done_valid <= 1'b1;
               end else begin
                  state    <= ST_SEND;
                  cur_frag <= 1'b0;
                  pend     <= c_split ? 2'd2 : 2'd1;
               end
            end
            ST_SEND: if (mreq_ready) begin
               if (!cur_frag && r_split) cur_frag <= 1'b1;
               else                      state    <= ST_WAIT;
            end
            default: ;
         endcase
         if (resp_fire) begin
            pend <= pend - 2'd1;
            if (pend == 2'd1) begin
               state      <= ST_IDLE;
               done_valid <= 1'b1;
               done_fault <= 1'b0;
               done_err   <= 1'b0;
            end
         end
      end
   end

   // request port
   mcmd_e cmd;
   always_comb begin
      if (r_write) cmd = r_lock ? MCMD_WRITE_COND : MCMD_WRITE;
      else         cmd = r_lock ? MCMD_READ_LOCK  : MCMD_READ;
   end

   assign mreq_valid = (state == ST_SEND);
   assign mreq_cmd   = cmd;
   assign mreq_frag  = cur_frag;
   assign mreq_addr  = cur_frag ? r_second_addr : r_addr;
   assign mreq_size  = cur_frag ? r_second : r_first;

   msplit_pack #(.DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)) u_pack (
      .wdata      (r_wdata),
      .frag       (cur_frag),
      .first_size (r_first),
      .frag_size  (mreq_size),
      .frag_wdata (mreq_wdata)
   );

   msplit_merge #(.DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)) u_merge (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (accept),
      .load_en     (resp_fire && !r_write),
      .frag        (mresp_frag),
      .first_size  (r_first),
      .second_size (r_second),
      .rdata       (mresp_rdata),
      .merged      (done_rdata)
   );

   // checks
   assert_size_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_size != '0) && (req_size <= SIZE_W'(DATA_BYTES)));

   assert_two_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> c_span_ok);

   assert_frag1_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && mreq_frag) |-> (mreq_addr[OFF_W-1:0] == '0));

   assert_abort_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && (done_fault || done_err)) |-> !mreq_valid);

   assert_split_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && mreq_frag) |-> (mreq_cmd == MCMD_READ || mreq_cmd == MCMD_WRITE));

   assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)
                                       && $stable(mreq_size) && $stable(mreq_frag)));

   assert_done_after_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_fault && !done_err) |-> $past(mresp_valid));

   assert_no_stray_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mresp_valid |-> (state != ST_IDLE));
endmodule

// File: tb/test_line_split_lsu.sv
`timescale 1ns/1ps
module test_line_split_lsu;
   localparam int AW = 8;
   localparam int BB = 8;
   localparam int DB = 4;
   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 0, req_write = 0, req_lock = 0, req_swap = 0;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_size = '0;
   logic [31:0]   req_wdata = '0;
   logic          xlat_fault0 = 0, xlat_fault1 = 0;
   logic          mreq_ready = 0;
   logic          mresp_valid = 0, mresp_frag = 0;
   logic [31:0]   mresp_rdata = '0;
   logic          req_ready, mreq_valid, mreq_frag, done_valid, done_fault, done_err;
   logic [1:0]    mreq_cmd;
   logic [AW-1:0] mreq_addr;
   logic [SW-1:0] mreq_size;
   logic [31:0]   mreq_wdata, done_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   line_split_lsu #(.ADDR_W(AW), .BLOCK_BYTES(BB), .DATA_BYTES(DB), .SIZE_W(SW)) i_line_split_lsu (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_lock(req_lock), .req_swap(req_swap), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata),
      .xlat_fault0(xlat_fault0), .xlat_fault1(xlat_fault1),
      .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_cmd(mreq_cmd),
      .mreq_frag(mreq_frag), .mreq_addr(mreq_addr), .mreq_size(mreq_size),
      .mreq_wdata(mreq_wdata),
      .mresp_valid(mresp_valid), .mresp_frag(mresp_frag), .mresp_rdata(mresp_rdata),
      .done_valid(done_valid), .done_fault(done_fault), .done_err(done_err),
      .done_rdata(done_rdata)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mb(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   function automatic logic [31:0] lowbytes(input logic [31:0] v, input int n);
      logic [31:0] r = '0;
      for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*i +: 8];
      return r;
   endfunction

   task automatic do_access(input bit wr, input bit lk, input bit sw, input bit f0,
                            input bit f1, input int a, input int sz, input int stall,
                            input bit rev);
      int blk2, fs, ss, nexp, got, cyc;
      bit split, abort, follow;
      logic [31:0] wd, exp_w, exp_r, rd;
      logic [1:0] exp_cmd;
      blk2  = ((a + sz - 1) / BB) * BB;
      split = blk2 > a;
      fs    = split ? blk2 - a : sz;
      ss    = sz - fs;
      abort = f0 || (split && f1) || (split && (lk || sw));
      wd    = 32'hA1B2C3D4 ^ (32'(a) * 32'h01030507);
      exp_cmd = wr ? (lk ? 2'd3 : 2'd2) : (lk ? 2'd1 : 2'd0);

      @(negedge clk);
      chk("R1 ready when idle", req_ready, 1);
      req_valid = 1; req_write = wr; req_lock = lk; req_swap = sw;
      req_addr = AW'(a); req_size = SW'(sz); req_wdata = wd;
      xlat_fault0 = f0; xlat_fault1 = f1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0; xlat_fault0 = 0; xlat_fault1 = 0;

      if (abort) begin
         bit is_fault = f0 || (split && f1);
         chk(is_fault ? "R4 fault completes" : "R5 lock/swap split completes",
             {done_valid, done_fault, done_err}, {1'b1, is_fault, !is_fault});
         chk(is_fault ? "R4 no request" : "R5 no request", mreq_valid, 0);
         @(negedge clk);
         chk(is_fault ? "R4 still no request" : "R5 still no request", mreq_valid, 0);
         chk("R7 done is a pulse", done_valid, 0);
         return;
      end

      chk("R1 busy after accept", req_ready, 0);
      nexp = split ? 2 : 1;
      got = 0; cyc = 0; follow = 0;
      while (got < nexp && cyc < 30) begin
         mreq_ready = (got > 0) || (cyc >= stall);
         if (follow) begin
            chk("R6 fragment 1 next cycle", {mreq_valid, mreq_frag}, 2'b11);
            follow = 0;
         end
         if (mreq_valid && mreq_ready) begin
            chk(split ? "R2 fragment index" : "R3 single fragment", mreq_frag, got);
            chk(split ? "R2 fragment address" : "R3 address", mreq_addr,
                (got == 0) ? a : blk2);
            chk(split ? "R2 fragment size" : "R3 size", mreq_size,
                (got == 0) ? fs : ss);
            chk("R3 command", mreq_cmd, exp_cmd);
            if (wr) begin
               exp_w = (got == 0) ? lowbytes(wd, fs) : lowbytes(wd >> (8 * fs), ss);
               chk("R9 store data", mreq_wdata, exp_w);
            end
            if (got == 0 && split) follow = 1;
            got++;
         end
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      mreq_ready = 0;
      chk("R3 fragment count", got, nexp);
      chk("R6 stall honoured", cyc, stall + nexp);

      for (int k = 0; k < nexp; k++) begin
         int fr, fa, fz;
         fr = (rev && split) ? nexp - 1 - k : k;
         fa = (fr == 0) ? a : blk2;
         fz = (fr == 0) ? fs : ss;
         chk("R7 no done while owed", done_valid, 0);
         for (int i = 0; i < 4; i++) rd[8*i +: 8] = (i < fz) ? mb(fa + i) : 8'hEE;
         mresp_valid = 1; mresp_frag = fr[0]; mresp_rdata = rd;
         @(posedge clk);
         @(negedge clk);
         mresp_valid = 0;
      end
      chk("R7 done after last response", {done_valid, done_fault, done_err}, 3'b100);
      if (!wr) begin
         exp_r = '0;
         for (int i = 0; i < sz; i++) exp_r[8*i +: 8] = mb(a + i);
         chk("R8 merged load data", done_rdata, exp_r);
      end
      @(negedge clk);
      chk("R7 done one cycle", done_valid, 0);
      chk("R1 idle again", req_ready, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset ready", req_ready, 1);
      chk("R1 reset no request", mreq_valid, 0);
      chk("R1 reset no done", done_valid, 0);
      rst_n = 1;

      for (int wr = 0; wr < 2; wr++)
         for (int sp = 0; sp < 3; sp++)
            for (int a = 0; a < 2 * BB; a++)
               do_access(wr[0], 0, 0, 0, 0, a, 1 << sp, (a + sp) % 3, a[0]);

      do_access(0, 0, 0, 1, 0, 6, 4, 0, 0);  // R4 fault on fragment 0, split
      do_access(1, 0, 0, 0, 1, 5, 4, 0, 0);  // R4 fault on fragment 1, split
      do_access(0, 0, 0, 1, 0, 0, 4, 0, 0);  // R4 fault, not split
      do_access(0, 0, 0, 0, 1, 2, 4, 1, 0);  // R4 fault1 ignored when not split
      do_access(0, 1, 0, 1, 0, 7, 2, 0, 0);  // R4 fault wins over lock error
      do_access(0, 1, 0, 0, 0, 7, 2, 0, 0);  // R5 locked load split
      do_access(1, 0, 1, 0, 0, 6, 4, 0, 0);  // R5 swap split
      do_access(0, 1, 0, 0, 0, 4, 4, 2, 0);  // R3 locked load, command 1
      do_access(1, 1, 0, 0, 0, 8, 2, 0, 0);  // R3 conditional store, command 3
      do_access(1, 0, 1, 0, 0, 12, 4, 1, 0); // R5 swap not split, command 2
      do_access(0, 0, 0, 0, 0, 5, 4, 4, 1);  // R6 long stall, R8 reversed

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R7 actual=hung expected=complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule